// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the arithmetic and logic unit of a small CPU datapath. It is purely combinational: two operands and a four-bit operation code go in, and a result word and a five-bit condition vector come out in the same cycle. The operation set covers addition, subtraction, the three bitwise logic operations, logical shifts in both directions, an arithmetic right shift, and signed and unsigned multiplication that keeps the low half of the product.

The condition vector lines up bit for bit with the low field of the processor flag register, so the surrounding core can latch it without reordering. The same operation codes serve both the register-register and the register-immediate instruction forms. The decoder places either a register value or the extended immediate on the second operand. Choosing operands, dividing and writing the flags back are the job of the surrounding core.

The operand width is a parameter (default 32, must be a power of two). The shift amount is taken from the low log2(WIDTH) bits of the second operand, which is bits [4:0] at the default width.

Top module: `alu_core`

## Requirements
- R1: With op_sel = 0 (add), result is opa + opb modulo 2^WIDTH and flag bit 0 (carry) is the carry out of the top bit.
- R2: With op_sel = 1 (subtract), result is opa - opb modulo 2^WIDTH and flag bit 0 is 1 exactly when a borrow occurs, that is when opa < opb as unsigned numbers.
- R3: For add and subtract, flag bit 1 (overflow) is 1 exactly when the two's-complement result does not fit in WIDTH bits.
- R4: op_sel = 2, 3 and 4 give opa XOR opb, opa OR opb and opa AND opb, with flag bits 0 and 1 both 0.
- R5: op_sel = 5 shifts opa left and op_sel = 6 shifts it right, filling with zeros, by the amount in the low log2(WIDTH) bits of opb; the higher bits of opb have no effect, and flag bits 0 and 1 are 0.
- R6: op_sel = 7 shifts opa right by the same amount, filling with copies of opa's top bit, with flag bits 0 and 1 at 0.
- R7: op_sel = 8 returns the low WIDTH bits of the signed product; flag bit 1 is 1 when the full signed product lies outside the signed WIDTH-bit range; flag bit 0 is 0.
- R8: op_sel = 9 returns the low WIDTH bits of the unsigned product; flag bit 1 is 1 when the full unsigned product is 2^WIDTH or larger; flag bit 0 is 0.
- R9: Flag bit 2 (zero) is 1 exactly when the result is all zeros, and flag bit 3 (sign) equals the result's top bit.
- R10: Flag bit 4 (odd) is 1 exactly when the result holds an odd number of one bits.
- R11: op_sel values 10 to 15 are unused: result is 0 and flags read 5'b00100.
- R12: The operation encoding is add 0, subtract 1, XOR 2, OR 3, AND 4, shift left 5, logical shift right 6, arithmetic shift right 7, signed multiply 8, unsigned multiply 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code |
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand, register value or extended immediate; low bits give the shift amount |
| result | output | WIDTH | Operation result |
| flags | output | 5 | Condition vector: bit 0 carry/borrow, bit 1 overflow, bit 2 zero, bit 3 sign, bit 4 odd parity |

## Verification
Whenever the inputs are defined, the embedded checks test how the results relate to each other. A reported borrow must match an unsigned less-than. Addition overflow needs operands of the same sign. A right shift must leave the expected top bit. A zero or unit multiplicand must give the obvious product without overflow. A zero flag rules out sign and odd. Logic, shift and unused codes must leave carry and overflow clear. These checks cannot show that a sum or product is numerically correct. The exact overflow boundaries of both multiply modes and the wrap at the extremes of the signed range show up only in the bench sweeps. The bench applies every operation to every operand pair at 8 bits and to a set of corner values at 32 bits.

// File: rtl/alu_pkg.sv
// Shared definitions for the ALU: operation codes, shift kinds and the
// bit positions of the condition vector. Assumes a 4-bit operation field.
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_XOR  = 4'd2,
        OP_OR   = 4'd3,
        OP_AND  = 4'd4,
        OP_SHL  = 4'd5,
        OP_SHR  = 4'd6,
        OP_SRA  = 4'd7,
        OP_MULS = 4'd8,
        OP_MULU = 4'd9
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RIGHT = 2'd1,
        SH_ARITH = 2'd2
    } shift_kind_e;

    localparam int FLAG_W     = 5;
    localparam int FLAG_CARRY = 0;
    localparam int FLAG_OVF   = 1;
    localparam int FLAG_ZERO  = 2;
    localparam int FLAG_SIGN  = 3;
    localparam int FLAG_ODD   = 4;

endpackage

// File: rtl/alu_addsub.sv
// Adder/subtractor for the ALU. One adder computes a + b or a + ~b + 1.
// The carry output is a borrow when subtracting. Overflow is signed
// two's-complement overflow. Assumes WIDTH >= 2.
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             subtract,
    output logic [WIDTH-1:0] sum,
    output logic             carry,
    output logic             overflow
);

    logic [WIDTH-1:0] b_eff;
    logic             cout;

    // Shared adder; borrow is the inverted carry-out when subtracting.
    always_comb begin
        b_eff       = subtract ? ~b : b;
        {cout, sum} = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, subtract};
        carry       = cout ^ subtract;
        overflow    = (a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
    end

    // Cross-checks of borrow and overflow against operand relations.
    always_comb begin
        if (!$isunknown({a, b, subtract})) begin
            assert_borrow_is_less_R2: assert (!subtract || (carry == (a < b)))
                else $error("borrow does not match unsigned compare");
            assert_add_ovf_same_sign_R3: assert (subtract || !overflow || (a[WIDTH-1] == b[WIDTH-1]))
                else $error("add overflow with operands of different sign");
            assert_sub_ovf_diff_sign_R3: assert (!subtract || !overflow || (a[WIDTH-1] != b[WIDTH-1]))
                else $error("subtract overflow with operands of equal sign");
        end
    end

endmodule

// File: rtl/alu_shift.sv
// Barrel shifter for the ALU: left, logical right and arithmetic right.
// A left shift reverses the bits, shifts right and reverses back, so a single
// log2(WIDTH)-stage right shifter serves all three kinds.
// Assumes WIDTH is a power of two.
module alu_shift
    import alu_pkg::*;
#(
    parameter  int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] value,
    input  logic [AMT_W-1:0] amount,
    input  shift_kind_e      kind,
    output logic [WIDTH-1:0] shifted
);

    function automatic logic [WIDTH-1:0] bit_reverse(input logic [WIDTH-1:0] x);
        logic [WIDTH-1:0] y;
        for (int i = 0; i < WIDTH; i++) y[i] = x[WIDTH-1-i];
        return y;
    endfunction

    logic [WIDTH-1:0] stage [0:AMT_W];
    logic             fill;

    // Stage input: reversed for left shifts; fill bit set only for arithmetic.
    always_comb begin
        stage[0] = (kind == SH_LEFT) ? bit_reverse(value) : value;
        fill     = (kind == SH_ARITH) & value[WIDTH-1];
    end

    // One stage per amount bit, each shifting by a power of two.
    for (genvar i = 0; i < AMT_W; i++) begin : g_stage
        localparam int STEP = 2 ** i;
        assign stage[i+1] = amount[i] ? {{STEP{fill}}, stage[i][WIDTH-1:STEP]} : stage[i];
    end

    // Undo the reversal for left shifts.
    always_comb begin
        shifted = (kind == SH_LEFT) ? bit_reverse(stage[AMT_W]) : stage[AMT_W];
    end

    // Fill-bit checks at the edges that a nonzero shift must vacate.
    always_comb begin
        if (!$isunknown({value, amount, kind})) begin
            assert_shr_top_clear_R5: assert (!(kind == SH_RIGHT && amount != '0) || !shifted[WIDTH-1])
                else $error("logical right shift left a one in the top bit");
            assert_shl_bottom_clear_R5: assert (!(kind == SH_LEFT && amount != '0) || !shifted[0])
                else $error("left shift left a one in bit 0");
            assert_sra_keeps_sign_R6: assert (kind != SH_ARITH || (shifted[WIDTH-1] == value[WIDTH-1]))
                else $error("arithmetic shift changed the sign bit");
        end
    end

endmodule

// File: rtl/alu_mul.sv
// Multiplier for the ALU: forms the full 2*WIDTH product of sign- or
// zero-extended operands and returns the low half. Overflow means the full
// product does not fit in WIDTH bits under the chosen signedness.
module alu_mul #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             signed_mode,
    output logic [WIDTH-1:0] low,
    output logic             overflow
);

    localparam int PW = 2 * WIDTH;

    logic [PW-1:0] ext_a;
    logic [PW-1:0] ext_b;
    logic [PW-1:0] prod;

    // Extend, multiply modulo 2^PW, then test the upper half.
    always_comb begin
        ext_a = signed_mode ? {{WIDTH{a[WIDTH-1]}}, a} : {{WIDTH{1'b0}}, a};
        ext_b = signed_mode ? {{WIDTH{b[WIDTH-1]}}, b} : {{WIDTH{1'b0}}, b};
        prod  = ext_a * ext_b;
        low   = prod[WIDTH-1:0];
        if (signed_mode) overflow = (prod[PW-1:WIDTH] != {WIDTH{prod[WIDTH-1]}});
        else             overflow = |prod[PW-1:WIDTH];
    end

    // Trivial factors must give trivial, non-overflowing products.
    always_comb begin
        if (!$isunknown({a, b, signed_mode})) begin
            assert_mul_by_zero_R7: assert (!(a == '0 || b == '0) || (low == '0 && !overflow))
                else $error("zero factor gave nonzero product or overflow");
            assert_mulu_by_one_R8: assert (!(b == WIDTH'(1)) || (low == a && !overflow))
                else $error("unit factor changed the operand");
        end
    end

endmodule

// File: rtl/alu_flags.sv
// Packs the condition vector: carry and overflow come from the selected
// unit; zero, sign and odd parity are derived from the result word.
module alu_flags
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]  result,
    input  logic              carry,
    input  logic              overflow,
    output logic [FLAG_W-1:0] flags
);

    // Place each condition at its fixed bit.
    always_comb begin
        flags             = '0;
        flags[FLAG_CARRY] = carry;
        flags[FLAG_OVF]   = overflow;
        flags[FLAG_ZERO]  = ~|result;
        flags[FLAG_SIGN]  = result[WIDTH-1];
        flags[FLAG_ODD]   = ^result;
    end

    // Consistency between the flags derived from the result.
    always_comb begin
        if (!$isunknown(result)) begin
            assert_zero_excludes_sign_R9: assert (!flags[FLAG_ZERO] || !flags[FLAG_SIGN])
                else $error("zero and sign both set");
            assert_odd_needs_ones_R10: assert (!flags[FLAG_ODD] || (result != '0))
                else $error("odd parity on an all-zero result");
        end
    end

endmodule

// File: rtl/alu_core.sv
// Top of the ALU. Drives operands to the adder, shifter and multiplier,
// selects one result by op_sel, and forms the flags. Fully combinational.
// Assumes WIDTH is a power of two and at least 4.
module alu_core
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]        op_sel,
    input  logic [WIDTH-1:0]  opa,
    input  logic [WIDTH-1:0]  opb,
    output logic [WIDTH-1:0]  result,
    output logic [FLAG_W-1:0] flags
);

    localparam int AMT_W = $clog2(WIDTH);

    logic [WIDTH-1:0] sum_w, shift_w, mul_w;
    logic             as_carry, as_ovf, mul_ovf;
    logic             is_sub, is_signed_mul;
    shift_kind_e      sh_kind;
    logic             sel_carry, sel_ovf;

    // Control decode for the shared units.
    always_comb begin
        is_sub        = (op_sel == OP_SUB);
        is_signed_mul = (op_sel == OP_MULS);
        case (op_sel)
            OP_SHL:  sh_kind = SH_LEFT;
            OP_SRA:  sh_kind = SH_ARITH;
            default: sh_kind = SH_RIGHT;
        endcase
    end

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a        (opa),
        .b        (opb),
        .subtract (is_sub),
        .sum      (sum_w),
        .carry    (as_carry),
        .overflow (as_ovf)
    );

    alu_shift #(.WIDTH(WIDTH)) u_shift (
        .value   (opa),
        .amount  (opb[AMT_W-1:0]),
        .kind    (sh_kind),
        .shifted (shift_w)
    );

    alu_mul #(.WIDTH(WIDTH)) u_mul (
        .a           (opa),
        .b           (opb),
        .signed_mode (is_signed_mul),
        .low         (mul_w),
        .overflow    (mul_ovf)
    );

    // Result and carry/overflow selection by operation code.
    always_comb begin
        result    = '0;
        sel_carry = 1'b0;
        sel_ovf   = 1'b0;
        case (op_sel)
            OP_ADD, OP_SUB: begin
                result    = sum_w;
                sel_carry = as_carry;
                sel_ovf   = as_ovf;
            end
            OP_XOR:                 result = opa ^ opb;
            OP_OR:                  result = opa | opb;
            OP_AND:                 result = opa & opb;
            OP_SHL, OP_SHR, OP_SRA: result = shift_w;
            OP_MULS, OP_MULU: begin
                result  = mul_w;
                sel_ovf = mul_ovf;
            end
            default:                result = '0;
        endcase
    end

    alu_flags #(.WIDTH(WIDTH)) u_flags (
        .result   (result),
        .carry    (sel_carry),
        .overflow (sel_ovf),
        .flags    (flags)
    );

    // Operations without arithmetic carry must report none at the port.
    always_comb begin
        if (!$isunknown({op_sel, opa, opb})) begin
            assert_logic_no_cv_R4: assert (!(op_sel inside {OP_XOR, OP_OR, OP_AND}) ||
                                           (!flags[FLAG_CARRY] && !flags[FLAG_OVF]))
                else $error("logic operation raised carry or overflow");
            assert_shift_no_cv_R5: assert (!(op_sel inside {OP_SHL, OP_SHR, OP_SRA}) ||
                                           (!flags[FLAG_CARRY] && !flags[FLAG_OVF]))
                else $error("shift raised carry or overflow");
            assert_mul_no_carry_R7: assert (!(op_sel inside {OP_MULS, OP_MULU}) || !flags[FLAG_CARRY])
                else $error("multiply raised carry");
            assert_unused_op_quiet_R11: assert (op_sel <= OP_MULU ||
                                                (result == '0 && flags == 5'b00100))
                else $error("unused operation code produced output");
        end
    end

endmodule

// File: tb/tb_alu_core.sv
// Bench for alu_core: directed corner sweep at 32 bits (instance dut) and an
// exhaustive sweep of all codes and operand pairs at 8 bits (dut_small).
// Delays are in ns; the 20 ns clock paces the watchdog only.
module tb_alu_core;

    localparam int SMALL_W  = 8;
    localparam int WATCHDOG = 180000;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [3:0]         op32, op8;
    logic [31:0]        a32, b32, r32;
    logic [SMALL_W-1:0] a8, b8, r8;
    logic [4:0]         f32, f8;

    alu_core #(.WIDTH(32)) dut (
        .op_sel (op32), .opa (a32), .opb (b32), .result (r32), .flags (f32)
    );

    alu_core #(.WIDTH(SMALL_W)) dut_small (
        .op_sel (op8), .opa (a8), .opb (b8), .result (r8), .flags (f8)
    );

    // Reference arithmetic on 64-bit values, masked to width w.
    function automatic void model(input int w, input logic [3:0] op,
                                  input logic [63:0] a, input logic [63:0] b,
                                  output logic [63:0] r, output logic c, output logic v);
        logic [63:0] mask, s, up, rr;
        longint      as_l, bs_l, p, rs;
        logic        sa, sb;
        int          sh;
        mask = (64'd1 << w) - 64'd1;
        sh   = int'(b & 64'(w - 1));
        sa   = a[w-1];
        sb   = b[w-1];
        as_l = sa ? longint'(a | ~mask) : longint'(a);
        bs_l = sb ? longint'(b | ~mask) : longint'(b);
        r = '0; c = 1'b0; v = 1'b0;
        case (op)
            4'd0: begin s = a + b; r = s & mask; c = s[w]; v = (sa == sb) && (r[w-1] != sa); end
            4'd1: begin s = a - b; r = s & mask; c = (a < b); v = (sa != sb) && (r[w-1] != sa); end
            4'd2: r = a ^ b;
            4'd3: r = a | b;
            4'd4: r = a & b;
            4'd5: r = (a << sh) & mask;
            4'd6: r = a >> sh;
            4'd7: r = 64'(as_l >>> sh) & mask;
            4'd8: begin
                p  = as_l * bs_l;
                rr = 64'(p) & mask;
                rs = rr[w-1] ? longint'(rr | ~mask) : longint'(rr);
                r  = rr;
                v  = (rs != p);
            end
            4'd9: begin up = a * b; r = up & mask; v = ((up >> w) != 64'd0); end
            default: r = '0;
        endcase
    endfunction

    function automatic string op_tag(input logic [3:0] op);
        case (op)
            4'd0:             return "R1 R3 R12";
            4'd1:             return "R2 R3 R12";
            4'd2, 4'd3, 4'd4: return "R4 R12";
            4'd5, 4'd6:       return "R5 R12";
            4'd7:             return "R6 R12";
            4'd8:             return "R7 R12";
            4'd9:             return "R8 R12";
            default:          return "R11";
        endcase
    endfunction

    task automatic expect_eq(input string tag, input string what,
                             input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Compare one vector: operation part, zero/sign, parity.
    task automatic check_vec(input int w, input logic [3:0] op,
                             input logic [63:0] a, input logic [63:0] b,
                             input logic [63:0] act_r, input logic [4:0] act_f);
        logic [63:0] er;
        logic        ec, ev;
        model(w, op, a, b, er, ec, ev);
        expect_eq(op_tag(op), "result/carry/ovf",
                  {act_r[61:0], act_f[1:0]}, {er[61:0], ev, ec});
        expect_eq("R9", "zero/sign", {62'd0, act_f[3:2]},
                  {62'd0, er[w-1], (er == 64'd0)});
        expect_eq("R10", "odd", {63'd0, act_f[4]}, {63'd0, ^er});
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL all-requirements watchdog actual=timeout expected=done");
            finish_run();
        end
    end

    initial begin
        logic [31:0] corners [11];
        corners = '{32'h0000_0000, 32'h0000_0001, 32'h0000_0002, 32'h7fff_ffff,
                    32'h8000_0000, 32'hffff_ffff, 32'h0001_0000, 32'h0000_0020,
                    32'hffff_ffe1, 32'h5555_aaaa, 32'h0000_001f};

        // Idle state: add of zeros gives zero result with only the zero flag (R9).
        op32 = 4'd0; a32 = '0; b32 = '0;
        op8  = 4'd0; a8  = '0; b8  = '0;
        #1;
        expect_eq("R9", "idle result", {32'd0, r32}, 64'd0);
        expect_eq("R9", "idle flags", {59'd0, f32}, {59'd0, 5'b00100});
        #1;

        // 32-bit corner pairs under every code, including unused ones (R11).
        // opb = 0x20 and 0xffffffe1 check that bits above [4:0] are ignored (R5).
        for (int op = 0; op < 16; op++) begin
            for (int i = 0; i < 11; i++) begin
                for (int j = 0; j < 11; j++) begin
                    op32 = 4'(op); a32 = corners[i]; b32 = corners[j];
                    #1;
                    check_vec(32, 4'(op), {32'd0, a32}, {32'd0, b32}, {32'd0, r32}, f32);
                    #1;
                end
            end
        end

        // Exhaustive 8-bit sweep of all codes and operand pairs (R1 to R12).
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < (1 << SMALL_W); a++) begin
                for (int b = 0; b < (1 << SMALL_W); b++) begin
                    op8 = 4'(op); a8 = SMALL_W'(a); b8 = SMALL_W'(b);
                    #1;
                    check_vec(SMALL_W, 4'(op), 64'(a), 64'(b), {56'd0, r8}, f8);
                    #1;
                end
            end
        end

        done = 1'b1;
        finish_run();
    end

endmodule